// File: doc/BRIEF.md
# Bank-Interleaved Burst Address Sequencer

This block feeds processing units that sit beside memory banks. Each unit owns an even and an odd bank. The host must touch only one bank of each pair, so the block walks a region with a large stride. A request carries a base address, a bank-parity select and a repeat count. The block then emits one 32-byte burst address per step on a valid/ready stream. Consecutive addresses are spaced by the burst size times the number of banks in a pseudo-channel, which is 512 bytes by default.

A burst of 32 bytes fills one entry of a unit's register file. The A half of that file has eight entries, so one sequence carries at most eight addresses. Once the last address of a non-empty sequence has been accepted, the block raises a single-cycle barrier request. It issues nothing further until the fence is reported complete. It then signals completion and accepts the next request. The DRAM controller and the data movement are handled elsewhere.

Top module: `pim_burst_addr_gen`

## Requirements
- R1: After reset, `start_ready` is 1 and `addr_valid`, `barrier_req` and `seq_done` are 0.
- R2: The first address of a sequence is `base_addr` plus 0 when `odd_bank` is 0, and `base_addr` plus 32 (BURST_BYTES) when `odd_bank` is 1. It appears with `addr_valid` in the cycle after the request is accepted.
- R3: Each address after the first is the previous address plus 512 (BURST_BYTES times BANKS), with wraparound modulo 2^ADDR_W.
- R4: A sequence issues exactly `rep_count` addresses when `rep_count` is 1 to 8. A `rep_count` of 9 to 15 issues 8 addresses.
- R5: A `rep_count` of 0 issues no address and no barrier request. `seq_done` pulses in the cycle after the request is accepted.
- R6: While `addr_valid` is 1 and `addr_ready` is 0, `addr_valid` stays 1 and `addr_out` stays unchanged.
- R7: `barrier_req` is a one-cycle pulse. It appears in the cycle after the final address handshake, and `addr_valid` is 0 during it.
- R8: After the barrier pulse, the block waits for `barrier_done`. `seq_done` pulses in the cycle after `barrier_done` is sampled high, and `start_ready` returns in the following cycle.
- R9: `start_ready` is 0 from acceptance until the `seq_done` pulse. A `start_valid` in that interval has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle, request taken on this edge |
| base_addr | input | ADDR_W | Region start address |
| odd_bank | input | 1 | 1 selects the odd bank of each pair |
| rep_count | input | CNT_W | Number of bursts requested |
| addr_valid | output | 1 | Burst address present |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | ADDR_W | Burst address |
| barrier_req | output | 1 | One-cycle fence request |
| barrier_done | input | 1 | Fence complete |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The accepted request shows up one edge later: either the first address is valid or, for an empty request, `seq_done` is high. Each address handshake exposes the next address, or the barrier pulse, at the following edge. `seq_done` follows one edge after `barrier_done` is sampled, and `start_ready` returns one edge after that. The bench drives inputs and samples outputs on the falling edge. Each check therefore reads the value settled by exactly the rising edges counted above. The bench also holds `addr_ready` low for extra cycles and holds back `barrier_done` to confirm that nothing moves early.

// File: rtl/pim_burst_addr_gen.sv
module pim_burst_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 32,
  parameter int BANKS       = 16,
  parameter int MAX_CNT     = 8,
  localparam int CNT_W      = $clog2(MAX_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              odd_bank,
  input  logic [CNT_W-1:0]  rep_count,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              barrier_req,
  input  logic              barrier_done,
  output logic              seq_done
);

  localparam int STRIDE = BURST_BYTES * BANKS;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_BAR, S_WAIT, S_FIN} state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  eff_cnt;

  assign eff_cnt = (rep_count > CNT_W'(MAX_CNT)) ? CNT_W'(MAX_CNT) : rep_count;

  assign start_ready = (state == S_IDLE);
  assign addr_valid  = (state == S_ISSUE);
  assign barrier_req = (state == S_BAR);
  assign seq_done    = (state == S_FIN);
  assign addr_out    = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      rem   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          cur   <= base_addr + (odd_bank ? ADDR_W'(BURST_BYTES) : ADDR_W'(0));
          rem   <= eff_cnt;
          state <= (eff_cnt == '0) ? S_FIN : S_ISSUE;
        end
        S_ISSUE: if (addr_ready) begin
          cur <= cur + ADDR_W'(STRIDE);
          rem <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) state <= S_BAR;
        end
        S_BAR:  state <= S_WAIT;
        S_WAIT: if (barrier_done) state <= S_FIN;
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  assert_stride_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready) |=>
      (!addr_valid || addr_out == ADDR_W'($past(addr_out) + ADDR_W'(STRIDE))));

  assert_barrier_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_req |=> !barrier_req);

  assert_barrier_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_req |-> !addr_valid);

  assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !start_ready);

  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (start_ready && !seq_done));

  assert_empty_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && rep_count != '0) |=> addr_valid);

endmodule

// File: tb/test_pim_burst_addr_gen.sv
module test_pim_burst_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_valid = 0;
  logic        start_ready;
  logic [31:0] base_addr = '0;
  logic        odd_bank = 0;
  logic [3:0]  rep_count = '0;
  logic        addr_valid;
  logic        addr_ready = 0;
  logic [31:0] addr_out;
  logic        barrier_req;
  logic        barrier_done = 0;
  logic        seq_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pim_burst_addr_gen i_pim_burst_addr_gen (
    .clk, .rst_n, .start_valid, .start_ready, .base_addr, .odd_bank, .rep_count,
    .addr_valid, .addr_ready, .addr_out, .barrier_req, .barrier_done, .seq_done
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic test_reset();
    chk("R1 start_ready", start_ready, 1);
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 barrier_req", barrier_req, 0);
    chk("R1 seq_done", seq_done, 0);
  endtask

  task automatic run_seq(logic [31:0] base, logic odd, logic [3:0] cnt, bit stall, bit poke);
    int n;
    logic [31:0] exp_a;
    n = (cnt > 8) ? 8 : cnt;
    @(negedge clk);
    chk("R9 idle before request", start_ready, 1);
    start_valid = 1; base_addr = base; odd_bank = odd; rep_count = cnt;
    @(negedge clk);
    start_valid = 0;
    if (n == 0) begin
      chk("R5 seq_done", seq_done, 1);
      chk("R5 no address", addr_valid, 0);
      chk("R5 no barrier", barrier_req, 0);
      @(negedge clk);
      chk("R8 start_ready back", start_ready, 1);
      return;
    end
    for (int i = 0; i < n; i++) begin
      exp_a = base + (odd ? 32'd32 : 32'd0) + 32'(i) * 32'd512;
      if (stall) begin
        addr_ready = 0;
        if (poke && i == 1) begin
          start_valid = 1; base_addr = 32'hDEAD0000; rep_count = 0;
        end
        @(negedge clk);
        start_valid = 0;
        chk("R6 valid held", addr_valid, 1);
        chk("R9 start_ready low while busy", start_ready, 0);
      end
      chk("R4 valid present", addr_valid, 1);
      chk((i == 0) ? "R2 first address" : "R3 stride address", addr_out, exp_a);
      addr_ready = 1;
      @(negedge clk);
      addr_ready = 0;
    end
    chk("R4 no extra address", addr_valid, 0);
    chk("R7 barrier pulse", barrier_req, 1);
    @(negedge clk);
    chk("R7 barrier one cycle", barrier_req, 0);
    if (poke) begin
      start_valid = 1; rep_count = 0;
    end
    @(negedge clk);
    start_valid = 0;
    chk("R8 waits for fence", seq_done, 0);
    chk("R9 ignored request", start_ready, 0);
    chk("R8 no address while waiting", addr_valid, 0);
    barrier_done = 1;
    @(negedge clk);
    barrier_done = 0;
    chk("R8 seq_done", seq_done, 1);
    @(negedge clk);
    chk("R8 start_ready back", start_ready, 1);
    chk("R8 seq_done single", seq_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    run_seq(32'h0000_1000, 0, 4'd3, 0, 0);
    run_seq(32'h0000_4000, 1, 4'd8, 1, 0);
    run_seq(32'h0010_0000, 0, 4'd12, 0, 0);
    run_seq(32'h0000_2000, 1, 4'd0, 0, 0);
    run_seq(32'h0000_8000, 1, 4'd1, 0, 0);
    run_seq(32'hFFFF_FC00, 1, 4'd4, 1, 1);
    summary();
  end
endmodule